// File: doc/BRIEF.md
# Clock Divider Setting Search Engine

This block picks the divider setting pair for a two-stage clock divider. The first stage divides by a linear divisor equal to m plus a configurable offset, and the second stage divides by a power of two given by the shift n. The parent rate is first divided by a pre-divide value and then by ten. The block is given the parent rate, the wanted output rate, the pre-divide value and the offset. It then looks for the (m, n) pair whose output rate comes closest to the wanted rate without going over it.

A search begins with a one-cycle `start` pulse while the block is idle. The block captures all of its inputs at that point. It then tries all 64 pairs in a fixed order and computes each candidate rate with a single shared restoring divider. When the last pair has been tried it raises `done` for one cycle. In the same cycle it presents the winning m, n and rate. These stay in place until the next search completes.

Top module: `clk_div_search`

## Requirements
- R1: A candidate's rate equals floor(floor(floor(parent / pre) / 10) >> n) / (m + offset). Every division truncates. m and n each take every value from 0 to 7 and are reported as plain binary on `best_m` and `best_n`.
- R2: No candidate whose rate is above the wanted rate can be chosen, so `best_rate` never exceeds the wanted rate captured at start.
- R3: The chosen pair has the smallest distance from the wanted rate among the pairs that qualify. Pairs are visited with m as the outer loop and n as the inner loop, both ascending. A later pair replaces the current best only when it is strictly closer, so on a tie the earlier pair wins.
- R4: When no candidate gives a nonzero rate at or below the target, the result is m = 0, n = 0 and rate = 0.
- R5: A pre-divide value of zero, or a linear divisor (m + offset) of zero, gives a candidate rate of 0.
- R6: `done` is high for exactly one cycle at the end of each accepted search.
- R7: A `start` pulse that arrives while a search is running is ignored. The running search finishes using the inputs it captured.
- R8: After reset `best_m`, `best_n`, `best_rate` and `done` are all 0. The three result outputs change only in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a search; ignored while busy |
| parent_rate | input | 32 | Parent clock rate, unsigned |
| target_rate | input | 32 | Wanted output rate, unsigned |
| pre_div | input | 8 | Pre-divide value |
| m_offset | input | 8 | Offset added to m to form the linear divisor |
| done | output | 1 | One-cycle pulse when the result is valid |
| best_m | output | 3 | Chosen linear setting m |
| best_n | output | 3 | Chosen shift setting n |
| best_rate | output | 32 | Rate given by the chosen pair |

## Verification
The failures that matter here are a wrong quotient in the shared divider, a wrong candidate index, or a wrong replacement test. None of these shows at the ports until `done` fires, about two thousand cycles after `start`. The visible symptom is then a wrong m, n or rate for that search. The bench therefore compares every result against a model that evaluates all 64 pairs. The stimulus includes ties between equal rates from different pairs, zero divisors and targets that admit nothing. It also pulses `start` again in the middle of a search and checks that the held outputs do not move while the search is still running.

// File: rtl/clk_div_search.sv
module clk_div_search #(
  parameter int RATE_W = 32,
  parameter int SET_W  = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] parent_rate,
  input  logic [RATE_W-1:0] target_rate,
  input  logic [SET_W-1:0]  pre_div,
  input  logic [SET_W-1:0]  m_offset,
  output logic              done,
  output logic [IDX_W-1:0]  best_m,
  output logic [IDX_W-1:0]  best_n,
  output logic [RATE_W-1:0] best_rate
);
  localparam int CNT_W = $clog2(RATE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(RATE_W - 1);
  localparam logic [IDX_W-1:0] MAX_IDX = '1;

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_NEXT} st_t;
  typedef enum logic [1:0] {PH_PRE, PH_TEN, PH_CAND} ph_t;

  st_t               st;
  ph_t               ph;
  logic [CNT_W-1:0]  cnt;
  logic [RATE_W-1:0] quo, dvs, tgt_q, base_q, bw_rate;
  logic [RATE_W:0]   rem;
  logic [SET_W-1:0]  off_q;
  logic [IDX_W-1:0]  m_i, n_i, bw_m, bw_n;

  logic [RATE_W:0]   rem_sh;
  logic              fits, last_pair, better;
  logic [RATE_W-1:0] quo_res;
  logic [IDX_W-1:0]  nxt_m, nxt_n;
  logic              ld_en;
  logic [RATE_W-1:0] ld_dnd, ld_dvs;

  assign rem_sh    = {rem[RATE_W-1:0], quo[RATE_W-1]};
  assign fits      = rem_sh >= {1'b0, dvs};
  assign quo_res   = (dvs == '0) ? '0 : quo;
  assign last_pair = (m_i == MAX_IDX) && (n_i == MAX_IDX);
  assign nxt_n     = (n_i == MAX_IDX) ? '0 : n_i + 1'b1;
  assign nxt_m     = (n_i == MAX_IDX) ? m_i + 1'b1 : m_i;
  assign better    = (ph == PH_CAND) && (quo_res <= tgt_q) && (quo_res > bw_rate);

  always_comb begin
    ld_en  = 1'b0;
    ld_dnd = '0;
    ld_dvs = '0;
    if (st == S_IDLE && start) begin
      ld_en  = 1'b1;
      ld_dnd = parent_rate;
      ld_dvs = RATE_W'(pre_div);
    end else if (st == S_NEXT) begin
      case (ph)
        PH_PRE: begin
          ld_en  = 1'b1;
          ld_dnd = quo_res;
          ld_dvs = RATE_W'(10);
        end
        PH_TEN: begin
          ld_en  = 1'b1;
          ld_dnd = quo_res;
          ld_dvs = RATE_W'(off_q);
        end
        default: begin
          ld_en  = !last_pair;
          ld_dnd = base_q >> nxt_n;
          ld_dvs = RATE_W'(nxt_m) + RATE_W'(off_q);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_PRE; cnt <= '0;
      quo <= '0; rem <= '0; dvs <= '0;
      tgt_q <= '0; off_q <= '0; base_q <= '0;
      m_i <= '0; n_i <= '0;
      bw_rate <= '0; bw_m <= '0; bw_n <= '0;
      done <= 1'b0; best_m <= '0; best_n <= '0; best_rate <= '0;
    end else begin
      done <= 1'b0;
      if (ld_en) begin
        quo <= ld_dnd;
        rem <= '0;
        dvs <= ld_dvs;
        cnt <= '0;
        st  <= S_DIV;
      end
      case (st)
        S_IDLE: if (start) begin
          tgt_q   <= target_rate;
          off_q   <= m_offset;
          ph      <= PH_PRE;
          bw_rate <= '0; bw_m <= '0; bw_n <= '0;
          m_i     <= '0; n_i <= '0;
        end
        S_DIV: begin
          rem <= fits ? rem_sh - {1'b0, dvs} : rem_sh;
          quo <= {quo[RATE_W-2:0], fits};
          cnt <= cnt + 1'b1;
          if (cnt == LAST_BIT) st <= S_NEXT;
        end
        S_NEXT: begin
          case (ph)
            PH_PRE: ph <= PH_TEN;
            PH_TEN: begin
              base_q <= quo_res;
              ph     <= PH_CAND;
            end
            default: begin
              if (better) begin
                bw_rate <= quo_res; bw_m <= m_i; bw_n <= n_i;
              end
              if (last_pair) begin
                done      <= 1'b1;
                best_rate <= better ? quo_res : bw_rate;
                best_m    <= better ? m_i : bw_m;
                best_n    <= better ? n_i : bw_n;
                st        <= S_IDLE;
              end else begin
                m_i <= nxt_m;
                n_i <= nxt_n;
              end
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_hold_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({best_m, best_n, best_rate}));
  p_not_above_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> best_rate <= tgt_q);
  p_work_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> bw_rate <= tgt_q);
  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start) |=> $stable({tgt_q, off_q}));
  p_zero_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_NEXT && ph == PH_CAND && dvs == '0) |-> !better);
endmodule

// File: tb/clk_div_search_tb.sv
module clk_div_search_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] parent_rate = '0, target_rate = '0;
  logic [7:0]  pre_div = '0, m_offset = '0;
  logic        done;
  logic [2:0]  best_m, best_n;
  logic [31:0] best_rate;

  typedef struct packed {
    logic [2:0]  m;
    logic [2:0]  n;
    logic [31:0] rate;
  } res_t;

  res_t exp_q[$];
  res_t last_res = '0;
  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic prev_done = 1'b0;

  always #2 clk = ~clk;

  clk_div_search u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .parent_rate(parent_rate), .target_rate(target_rate),
    .pre_div(pre_div), .m_offset(m_offset),
    .done(done), .best_m(best_m), .best_n(best_n), .best_rate(best_rate));

  function automatic res_t model(input logic [31:0] par, input logic [31:0] tgt,
                                 input logic [7:0] pre, input logic [7:0] off);
    res_t r;
    logic [31:0] base, cand;
    logic [8:0] d;
    r = '0;
    base = (pre == 0) ? 32'd0 : (par / pre) / 10;
    for (int m = 0; m < 8; m++) begin
      for (int n = 0; n < 8; n++) begin
        d = 9'(m) + 9'(off);
        cand = (d == 0) ? 32'd0 : (base >> n) / 32'(d);
        if (cand > tgt) continue;
        if ((tgt - cand) < (tgt - r.rate)) begin
          r.rate = cand; r.m = 3'(m); r.n = 3'(n);
        end
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] par, input logic [31:0] tgt,
                     input logic [7:0] pre, input logic [7:0] off, input bit poke);
    @(negedge clk);
    parent_rate = par; target_rate = tgt; pre_div = pre; m_offset = off;
    exp_q.push_back(model(par, tgt, pre, off));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (300) @(negedge clk);
      parent_rate = 32'h0123_4567; target_rate = 32'hFFFF_FFFF;
      pre_div = 8'd1; m_offset = 8'd3;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R8 outputs held mid-search", {best_m, best_n, best_rate},
            {last_res.m, last_res.n, last_res.rate});
    end
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && done) check("R6 done longer than one cycle", 1, 0);
      if (done) begin
        if (exp_q.size() == 0) check("R7 unexpected result", 1, 0);
        else begin
          res_t e;
          e = exp_q.pop_front();
          check("R1 R3 result m", best_m, e.m);
          check("R1 R3 result n", best_n, e.n);
          check("R1 R2 result rate", best_rate, e.rate);
          last_res = '{m: best_m, n: best_n, rate: best_rate};
        end
      end
    end
    prev_done = done;
  end

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] p, b, t;
    logic [7:0] pr, of;
    repeat (4) @(negedge clk);
    check("R8 reset outputs", {done, best_m, best_n, best_rate}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle after reset", {done, best_m, best_n, best_rate}, 0);
    run(32'd297_000_000, 32'd100_000, 8'd1, 8'd1, 1'b0);
    run(32'd24_000_000, 32'hFFFF_FFFF, 8'd2, 8'd1, 1'b0);
    run(32'd100_000_000, 32'd5_000_000, 8'd1, 8'd1, 1'b0);   // R3 tie: m=0,n=1 vs m=1,n=0
    run(32'd50_000_000, 32'd400_000, 8'd0, 8'd1, 1'b0);      // R5 zero pre-divide, R4
    run(32'd50_000_000, 32'd0, 8'd1, 8'd1, 1'b0);            // R4 zero target
    run(32'd50_000_000, 32'd3, 8'd4, 8'd0, 1'b0);            // R5 zero divisor at m=0
    run(32'd7, 32'd1000, 8'd1, 8'd1, 1'b0);                  // R4 base of zero
    run(32'd300_000_000, 32'd1_234_567, 8'd3, 8'd2, 1'b1);   // R7 busy start
    check("R7 queue drained", exp_q.size(), 0);
    for (int i = 0; i < 24; i++) begin
      p  = $urandom;
      pr = 8'($urandom_range(0, 12));
      of = 8'($urandom_range(0, 4));
      b  = (pr == 0) ? 32'd1 : (p / pr) / 10 + 1;
      t  = $urandom % b;
      run(p, t, pr, of, (i % 6) == 0);
    end
    summary();
  end
endmodule